// File: doc/BRIEF.md
# Backup-State Wakeup Pin Monitor

This block watches a bank of external wakeup pins while the system sits in a low-power backup state. It runs on the slow 32 kHz clock. Software chooses, per pin, whether the pin may wake the system and which level counts as active. All pins share one debounce length chosen from a small fixed set. A pin counts only after it has held its active level for the whole debounce window. When one or more enabled pins qualify, the block raises a wake request and records the set of pins that caused it.

Pin inputs are brought into the clock domain through a two-stage synchronizer before polarity correction and debouncing. Configuration is written through a small register port. That port accepts writes only while the system is awake, so the configuration stays frozen for the whole monitoring period. The cause mask outlives the wake request. Software reads it after the system resumes and clears it with a write-one-to-clear access. Entering backup again also clears it.

Top module: `wkpin_ctrl`

## Requirements
- R1: After reset, wake_req_o is 0, cause_o is 0, and the enable, polarity and debounce registers all read 0.
- R2: A write to address 0 sets the enable bits that are 1 in the data. A write to address 1 clears those bits. Reading address 0 returns the enable mask.
- R3: A write to address 2 sets polarity bits and a write to address 3 clears them. Reading address 2 returns the mask. A polarity bit of 0 makes its pin active low and a 1 makes it active high.
- R4: Address 4, bits [2:0], selects the debounce length N in clock cycles: code 0 gives 1 (off), 1 gives 2, 2 gives 3, 3 gives 32, 4 gives 512, 5 gives 4096, and 6 or 7 give 32768. Reading address 4 returns the code.
- R5: Pins pass through two synchronizing flops. With debounce off, an enabled pin that reaches its active level before clock edge k raises wake_req_o after edge k+2, provided backup_i was already high in earlier cycles.
- R6: With debounce length N, wake_req_o rises after edge k+N+1 for a pin that turned active before edge k and held. A pin that leaves its active level earlier restarts its count, and a shorter pulse causes no wakeup.
- R7: A pin whose enable bit is 0 never raises wake_req_o and never appears in cause_o.
- R8: On the cycle wake_req_o rises, cause_o takes the mask of every pin that qualified in that cycle. The mask is nonzero and stays unchanged while wake_req_o is high.
- R9: wake_req_o returns to 0 one cycle after backup_i falls. cause_o keeps its value after backup_i falls.
- R10: Writing 1s to address 5 while backup_i is low clears those bits of cause_o. A rising edge of backup_i clears cause_o.
- R11: Bus writes made while backup_i is high leave every register unchanged.
- R12: bus_rdata returns the cause mask at address 5 and 0 at addresses 1, 3, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz monitoring clock |
| rst_n | input | 1 | Synchronous active-low reset |
| backup_i | input | 1 | High while the system is in the backup state |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| pins_i | input | NPINS | Asynchronous external wakeup pins |
| wake_req_o | output | 1 | Wake request to the power controller |
| cause_o | output | NPINS | Latched mask of the pins that caused the last wakeup |

## Verification
The assertions take for granted that backup_i only changes together with the power sequencing, so software sees no cause-clear write while a wake request is pending, and that reset leaves backup_i low. The stimulus drives every bus write and every pin change half a cycle away from the active edge. It writes configuration only while backup_i is low. It first writes inside backup on purpose to show those writes are dropped. It always enters backup with every pin at its inactive level, so each measured wake latency starts from a known edge.

// File: rtl/wkpin_pkg.sv
// Shared definitions for the wakeup pin monitor.
// Holds the register map, the debounce code type and the code-to-length function.
package wkpin_pkg;

    localparam int ADDR_W  = 3;
    localparam int CNT_W   = 16;

    localparam logic [ADDR_W-1:0] A_EN_SET  = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_POL_SET = 3'd2;
    localparam logic [ADDR_W-1:0] A_POL_CLR = 3'd3;
    localparam logic [ADDR_W-1:0] A_DEB     = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAUSE   = 3'd5;

    typedef enum logic [2:0] {
        DB_OFF   = 3'd0,
        DB_2     = 3'd1,
        DB_3     = 3'd2,
        DB_32    = 3'd3,
        DB_512   = 3'd4,
        DB_4096  = 3'd5,
        DB_32768 = 3'd6,
        DB_ALT   = 3'd7
    } deb_code_e;

    // Terminal count (N-1) for a debounce code.
    function automatic logic [CNT_W-1:0] deb_last(input deb_code_e code);
        case (code)
            DB_OFF:  deb_last = CNT_W'(0);
            DB_2:    deb_last = CNT_W'(1);
            DB_3:    deb_last = CNT_W'(2);
            DB_32:   deb_last = CNT_W'(31);
            DB_512:  deb_last = CNT_W'(511);
            DB_4096: deb_last = CNT_W'(4095);
            default: deb_last = CNT_W'(32767);
        endcase
    endfunction

endpackage

// File: rtl/wkpin_regs.sv
// Configuration registers: enable and polarity masks with set/clear access,
// and the shared debounce code.
// Assumes: writes are accepted only when backup_i is low; NPINS >= 3.
module wkpin_regs
    import wkpin_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              backup_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  pol_o,
    output deb_code_e         deb_o
);

    logic wr_ok;
    assign wr_ok = wr_en && !backup_i;

    // Update the configuration on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= '0;
            pol_o <= '0;
            deb_o <= DB_OFF;
        end else if (wr_ok) begin
            case (addr)
                A_EN_SET:  en_o  <= en_o | wdata;
                A_EN_CLR:  en_o  <= en_o & ~wdata;
                A_POL_SET: pol_o <= pol_o | wdata;
                A_POL_CLR: pol_o <= pol_o & ~wdata;
                A_DEB:     deb_o <= deb_code_e'(wdata[2:0]);
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/wkpin_sync.sv
// Multi-flop synchronizer for the asynchronous pin inputs.
// Assumes: each pin is a slow level signal; one bit per pin, no bus coherence.
module wkpin_sync #(
    parameter int NPINS  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d_i,
    output logic [NPINS-1:0] q_o
);

    logic [NPINS-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-samples the one before.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wkpin_debounce.sv
// Per-pin debounce counters. A pin qualifies once it has been active for
// last_i+1 consecutive cycles, counting the current one.
// Assumes: last_i is stable while run_i is high; counters idle when run_i is low.
module wkpin_debounce
    import wkpin_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [NPINS-1:0] act_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [NPINS-1:0] qual_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(32767);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [CNT_W-1:0] cnt_q;

        // Count consecutive active cycles; restart on any inactive cycle.
        always_ff @(posedge clk) begin
            if (!rst_n || !run_i || !act_i[p]) cnt_q <= '0;
            else if (cnt_q != CNT_SAT)         cnt_q <= cnt_q + 1'b1;
        end

        assign qual_o[p] = act_i[p] && (cnt_q >= last_i);
    end

endmodule

// File: rtl/wkpin_ctrl.sv
// Wakeup pin monitor top: synchronizes the pins, applies polarity and enable,
// debounces, and raises a wake request with a latched cause mask.
// Assumes: backup_i is synchronous to clk; no cause-clear writes while in backup.
module wkpin_ctrl
    import wkpin_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              backup_i,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pins_i,
    output logic              wake_req_o,
    output logic [NPINS-1:0]  cause_o
);

    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] pol_q;
    deb_code_e        deb_q;
    logic [NPINS-1:0] pins_s;
    logic [NPINS-1:0] active;
    logic [NPINS-1:0] qual;
    logic             bk_q;
    logic             entry;

    wkpin_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .backup_i(backup_i),
        .wr_en(bus_wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .en_o(en_q), .pol_o(pol_q), .deb_o(deb_q)
    );

    wkpin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_s)
    );

    // A pin is active when enabled and at the level its polarity selects.
    assign active = en_q & ~(pins_s ^ pol_q);

    wkpin_debounce #(.NPINS(NPINS)) u_deb (
        .clk(clk), .rst_n(rst_n), .run_i(backup_i),
        .act_i(active), .last_i(deb_last(deb_q)), .qual_o(qual)
    );

    assign entry = backup_i && !bk_q;

    // Remember the previous backup state to detect entry.
    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= 1'b0;
        else        bk_q <= backup_i;
    end

    // Wake request: set on the first qualifying cycle, dropped on exit.
    always_ff @(posedge clk) begin
        if (!rst_n || !backup_i)                   wake_req_o <= 1'b0;
        else if (!entry && !wake_req_o && |qual)   wake_req_o <= 1'b1;
    end

    // Cause mask: cleared on entry or by write-one-to-clear, captured with the request.
    always_ff @(posedge clk) begin
        if (!rst_n || entry)
            cause_o <= '0;
        else if (backup_i && !wake_req_o && |qual)
            cause_o <= qual;
        else if (!backup_i && bus_wr_en && bus_addr == A_CAUSE)
            cause_o <= cause_o & ~bus_wdata;
    end

    // Read mux.
    always_comb begin
        case (bus_addr)
            A_EN_SET:  bus_rdata = en_q;
            A_POL_SET: bus_rdata = pol_q;
            A_DEB:     bus_rdata = NPINS'(deb_q);
            A_CAUSE:   bus_rdata = cause_o;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wkpin_ctrl_chk.sv
// Temporal checks on the wakeup pin monitor, bound into every instance.
// Assumes: backup_i low during reset.
module wkpin_ctrl_chk #(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             backup_i,
    input logic             wake_req_o,
    input logic [NPINS-1:0] cause_o,
    input logic [NPINS-1:0] en_q
);

    // R9
    wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !backup_i |=> !wake_req_o);

    // R8
    cause_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req_o) |-> (cause_o != '0));

    // R8
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && $past(wake_req_o)) |-> $stable(cause_o));

    // R7
    cause_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req_o) |-> ((cause_o & ~en_q) == '0));

    // R10
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_i && !$past(backup_i)) |=> (cause_o == '0));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_i |=> $stable(en_q));

endmodule

bind wkpin_ctrl wkpin_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .backup_i(backup_i),
    .wake_req_o(wake_req_o), .cause_o(cause_o), .en_q(en_q)
);

// File: tb/wkpin_ctrl_bench.sv
module wkpin_ctrl_bench;

    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          backup_i = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pins_i = '0;
    logic          wake_req_o;
    logic [NP-1:0] cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wkpin_ctrl #(.NPINS(NP), .SYNC_STAGES(2)) u_wkpin_ctrl (
        .clk(clk), .rst_n(rst_n), .backup_i(backup_i),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pins_i(pins_i),
        .wake_req_o(wake_req_o), .cause_o(cause_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [NP-1:0] pin_hist[$];
    int            run_len[NP];
    logic [NP-1:0] m_en, m_pol, m_cause;
    int            m_code;
    bit            m_wake, m_bk;

    function automatic int need(int code);
        case (code)
            0: return 1;     1: return 2;    2: return 3;
            3: return 32;    4: return 512;  5: return 4096;
            default: return 32768;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pin_hist = {'0, '0};
            foreach (run_len[i]) run_len[i] = 0;
            m_en = '0; m_pol = '0; m_cause = '0; m_code = 0;
            m_wake = 0; m_bk = 0;
        end else begin
            logic [NP-1:0] seen, qual, ncause;
            bit nwake;
            seen = pin_hist[0];
            qual = '0;
            for (int i = 0; i < NP; i++) begin
                bit act;
                act = m_en[i] && (seen[i] == m_pol[i]);
                if (act && run_len[i] + 1 >= need(m_code)) qual[i] = 1'b1;
                if (backup_i && act) run_len[i] = (run_len[i] < 32767) ? run_len[i] + 1 : 32767;
                else run_len[i] = 0;
            end
            nwake = m_wake; ncause = m_cause;
            if (!backup_i) nwake = 0;
            else if (m_bk && !m_wake && qual != '0) begin nwake = 1; ncause = qual; end
            if (backup_i && !m_bk) ncause = '0;
            if (!backup_i && bus_wr_en) begin
                case (bus_addr)
                    3'd0: m_en  = m_en | bus_wdata;
                    3'd1: m_en  = m_en & ~bus_wdata;
                    3'd2: m_pol = m_pol | bus_wdata;
                    3'd3: m_pol = m_pol & ~bus_wdata;
                    3'd4: m_code = int'(bus_wdata[2:0]);
                    3'd5: ncause = ncause & ~bus_wdata;
                    default: ;
                endcase
            end
            void'(pin_hist.pop_front());
            pin_hist.push_back(pins_i);
            m_bk = backup_i; m_wake = nwake; m_cause = ncause;
        end
    end

    // Compare outputs against the model on every falling edge (R5 R6 R8 R9 R10).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (wake_req_o !== m_wake || cause_o !== m_cause) begin
                errors++;
                $display("FAIL R5 R6 R8 R9 R10 model: wake=%0b cause=%h expected wake=%0b cause=%h",
                         wake_req_o, cause_o, m_wake, m_cause);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [NP-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    // Idle pins at their inactive level, enter backup, settle.
    task automatic enter_backup();
        @(negedge clk);
        pins_i = ~m_pol;
        cyc(3);
        backup_i = 1'b1;
        cyc(2);
    endtask

    task automatic leave_backup();
        @(negedge clk);
        backup_i = 1'b0;
        pins_i = ~m_pol;
        cyc(3);
    endtask

    // Drive a pin active at a negedge; wake must rise after edge k+N+1.
    task automatic timed_wake(input string req, input int pin, input int n);
        @(negedge clk);
        pins_i[pin] = m_pol[pin];
        cyc(n + 1);
        check(req, {15'b0, wake_req_o}, 16'h0);
        cyc(1);
        check(req, {15'b0, wake_req_o}, 16'h1);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1
        check("R1 wake", {15'b0, wake_req_o}, 16'h0);
        check("R1 cause", cause_o, 16'h0);
        rd("R1 enable", 3'd0, 16'h0);
        rd("R1 polarity", 3'd2, 16'h0);
        rd("R1 debounce", 3'd4, 16'h0);

        // R2 R3
        wr(3'd0, 16'h00FF); wr(3'd1, 16'h000F);
        rd("R2 enable mask", 3'd0, 16'h00F0);
        wr(3'd2, 16'h0030); wr(3'd3, 16'h0010);
        rd("R3 polarity mask", 3'd2, 16'h0020);
        // R12
        rd("R12 unmapped 1", 3'd1, 16'h0);
        rd("R12 unmapped 3", 3'd3, 16'h0);
        rd("R12 unmapped 7", 3'd7, 16'h0);

        // R5: debounce off, active-low pin 4
        enter_backup();
        timed_wake("R5 off latency", 4, 1);
        check("R8 cause pin4", cause_o, 16'h0010);
        // R11: writes in backup dropped
        wr(3'd0, 16'hFF00); wr(3'd4, 16'h0003);
        leave_backup();
        check("R9 wake low after exit", {15'b0, wake_req_o}, 16'h0);
        check("R9 cause held", cause_o, 16'h0010);
        rd("R11 enable unchanged", 3'd0, 16'h00F0);
        rd("R11 debounce unchanged", 3'd4, 16'h0);
        rd("R12 cause read", 3'd5, 16'h0010);
        wr(3'd5, 16'h0010);
        check("R10 cause cleared", cause_o, 16'h0);

        // R6: N=2, active-high pin 5, a 1-cycle glitch first
        wr(3'd4, 16'h0001);
        rd("R4 code readback", 3'd4, 16'h0001);
        enter_backup();
        @(negedge clk); pins_i[5] = 1'b1;
        @(negedge clk); pins_i[5] = 1'b0;
        cyc(6);
        check("R6 glitch ignored", {15'b0, wake_req_o}, 16'h0);
        timed_wake("R6 N=2 latency", 5, 2);
        check("R6 cause pin5", cause_o, 16'h0020);
        leave_backup();

        // R6 R4: N=32, a 20-cycle pulse then a held level
        wr(3'd4, 16'h0003);
        enter_backup();
        @(negedge clk); pins_i[6] = 1'b0;
        cyc(20); pins_i[6] = 1'b1;
        cyc(10);
        check("R6 short pulse restarts", {15'b0, wake_req_o}, 16'h0);
        timed_wake("R4 N=32 latency", 6, 32);
        leave_backup();

        // R7: disabled pin 0 toggling, enabled pins idle
        wr(3'd0, 16'h00FF); wr(3'd1, 16'h0001); wr(3'd4, 16'h0000);
        enter_backup();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); pins_i[0] = ~pins_i[0];
        end
        cyc(4);
        check("R7 disabled no wake", {15'b0, wake_req_o}, 16'h0);
        check("R7 disabled no cause", cause_o, 16'h0);
        // R8: two pins together
        @(negedge clk); pins_i[1] = m_pol[1]; pins_i[2] = m_pol[2];
        cyc(3);
        check("R8 two-pin cause", cause_o, 16'h0006);
        leave_backup();
        // R10: re-entry clears cause
        enter_backup();
        check("R10 entry clears", cause_o, 16'h0);
        leave_backup();

        // R4: code 2 (N=3), code 5 (N=4096), code 7 (N=32768)
        wr(3'd4, 16'h0002);
        enter_backup(); timed_wake("R4 N=3 latency", 3, 3); leave_backup();
        wr(3'd4, 16'h0005);
        enter_backup(); timed_wake("R4 N=4096 latency", 7, 4096); leave_backup();
        wr(3'd4, 16'h0007);
        enter_backup(); timed_wake("R4 code7 N=32768 latency", 5, 32768); leave_backup();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule